// File: doc/BRIEF.md
# TDM clock and frame pulse generator

This block turns a system-clock phase accumulator into the timing signals of a TDM interface. The accumulator adds a frequency word every system cycle, and each carry out of its top bit is one overflow tick. A four-state phase machine advances on those ticks and produces two clocks. The first is a double-rate clock. The second is a common clock at half that rate, formed by dividing the double-rate clock by two. A frame counter counts double-rate cycles and marks an 8 kHz frame reference.

The frequency word is sized for the fast rate. At the fast rate every tick advances the phase machine. At the slow rate a prescaler lets through one tick in four, so the same word serves both rates. A rate select, a frame pulse polarity and a frame pulse width code come in as plain static inputs. The rate and the width are captured only when a frame starts, so the outputs never carry a runt or a shortened pulse. All three outputs leave the block from flops that update in the same system cycle.

Phase machine states: `PH_BOTH_LO` (both clocks low, the reset state), `PH_BOTH_HI` (both high), `PH_X1_ONLY` (common clock high, double-rate low) and `PH_X2_ONLY` (double-rate high, common clock low). On each enabled tick the machine steps through the ring BOTH_LO → BOTH_HI → X1_ONLY → X2_ONLY → BOTH_LO. A double-rate rising edge is the entry into BOTH_HI or X2_ONLY. Without an enabled tick the machine holds its state.

Top module: `tdm_timing_gen`

## Requirements
- R1: While `rst_n` is low, after a clock edge, `tclk_o` = 0, `tclk2x_o` = 0 and `frm_o` equals the inverse of `frm_pol_i`.
- R2: When the fast rate is active (`rate_hi_i` = 1 captured), each overflow tick is one half-period of `tclk2x_o`. When the slow rate is active (0), each half-period takes four ticks. With a frequency word of 2^(ACC_W-1), a tick comes every 2 system cycles, so `tclk2x_o` has a period of 4 cycles (fast) or 16 cycles (slow), with equal high and low halves.
- R3: `tclk_o` changes only in a cycle where `tclk2x_o` rises, and it toggles on every such rise, so it has half the double-rate frequency.
- R4: A frame lasts 2048 double-rate cycles (1024 common-clock cycles) at the fast rate, or 512 double-rate cycles (256 common-clock cycles) at the slow rate. Both come to 8192 system cycles under the R2 word. A frame starts in the cycle where `tclk2x_o` and `tclk_o` both rise.
- R5: The frame pulse is active from the frame start for (`frm_wid_i` + 1) double-rate cycles, that is 1 to 4.
- R6: `frm_pol_i` = 1 makes the active level of `frm_o` high; 0 makes it low. A change of `frm_pol_i` reaches `frm_o` at the next clock edge.
- R7: A change of `rate_hi_i` or `frm_wid_i` in the middle of a frame leaves that frame unchanged and takes effect from the next frame start.
- R8: With a frequency word of zero, no ticks occur, and all three outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| nco_word_i | input | ACC_W | Phase accumulator increment, sized for the fast rate |
| rate_hi_i | input | 1 | 1 = fast rate (8.192 MHz common clock), 0 = slow rate (2.048 MHz) |
| frm_pol_i | input | 1 | 1 = frame pulse active high, 0 = active low |
| frm_wid_i | input | WID_W | Frame pulse width minus one, in double-rate cycles |
| tclk_o | output | 1 | Common clock |
| tclk2x_o | output | 1 | Double-rate common clock |
| frm_o | output | 1 | 8 kHz frame pulse |

## Verification
The phase and frame registers change one system cycle after the tick that moves them, and the output flops add one more cycle, so all three outputs move together. The bench therefore compares them with each other at falling edges rather than counting from the frequency word. A polarity change is due at the first rising edge after it is driven, and it is checked at the falling edge that follows. A rate or width change is due only at the next frame start, so each frame is measured from one observed pulse start to the next. Its length, edge counts, first half-period and pulse width are compared with the values for the settings in force at that frame's start.

// File: rtl/tdm_timing_pkg.sv
package tdm_timing_pkg;
    // Phase of the clock pair: which of the double-rate and common clocks is high
    typedef enum logic [1:0] {
        PH_BOTH_LO = 2'd0,
        PH_BOTH_HI = 2'd1,
        PH_X1_ONLY = 2'd2,
        PH_X2_ONLY = 2'd3
    } phase_e;
endpackage

// File: rtl/tdm_nco.sv
module tdm_nco #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] word_i,
    output logic             tick_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, word_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            acc_q  <= sum[ACC_W-1:0];
            tick_o <= sum[ACC_W];
        end
    end
endmodule

// File: rtl/tdm_phase_fsm.sv
module tdm_phase_fsm
    import tdm_timing_pkg::*;
#(
    parameter int PRESCALE = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick_i,
    input  logic   rate_hi_i,
    output phase_e phase_o,
    output logic   rise_o
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;

    phase_e        state_q, state_d;
    logic [PW-1:0] pre_q;
    logic          step;

    assign step = tick_i && (rate_hi_i || (pre_q == PW'(PRESCALE - 1)));

    always_comb begin
        unique case (state_q)
            PH_BOTH_LO: state_d = PH_BOTH_HI;
            PH_BOTH_HI: state_d = PH_X1_ONLY;
            PH_X1_ONLY: state_d = PH_X2_ONLY;
            PH_X2_ONLY: state_d = PH_BOTH_LO;
            default:    state_d = PH_BOTH_LO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    state_q <= PH_BOTH_LO;
        else if (step) state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (step)   pre_q <= '0;
        else if (tick_i) pre_q <= pre_q + 1'b1;
    end

    assign phase_o = state_q;
    assign rise_o  = step && (state_q == PH_BOTH_LO || state_q == PH_X1_ONLY);

    // R8: without a tick in the previous cycle the phase must not move
    assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_i) |-> $stable(state_q));
endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr #(
    parameter int LO_X1 = 256,
    parameter int HI_X1 = 1024,
    parameter int WID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             rate_req_i,
    input  logic [WID_W-1:0] wid_req_i,
    output logic             rate_act_o,
    output logic             frame_act_o
);
    localparam int LAST_LO = 2 * LO_X1 - 1;
    localparam int LAST_HI = 2 * HI_X1 - 1;
    localparam int CW      = $clog2(2 * HI_X1);

    logic [CW-1:0]    cnt_q;
    logic             rate_q;
    logic [WID_W-1:0] wid_q;
    logic             at_last;

    assign at_last = (cnt_q == (rate_q ? CW'(LAST_HI) : CW'(LAST_LO)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= CW'(LAST_LO);
            rate_q <= 1'b0;
            wid_q  <= '0;
        end else if (rise_i) begin
            if (at_last) begin
                cnt_q  <= '0;
                rate_q <= rate_req_i;
                wid_q  <= wid_req_i;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    assign rate_act_o  = rate_q;
    assign frame_act_o = (cnt_q <= {{(CW-WID_W){1'b0}}, wid_q});

    // R7: captured settings move only when a new frame has just begun
    assert_rate_at_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_q) |-> (cnt_q == '0));
    assert_wid_at_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wid_q) |-> (cnt_q == '0));
    // R4: the count never passes the longest frame
    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LAST_HI));
endmodule

// File: rtl/tdm_timing_gen.sv
module tdm_timing_gen
    import tdm_timing_pkg::*;
#(
    parameter int ACC_W    = 32,
    parameter int LO_X1    = 256,
    parameter int HI_X1    = 1024,
    parameter int PRESCALE = 4,
    parameter int WID_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] nco_word_i,
    input  logic             rate_hi_i,
    input  logic             frm_pol_i,
    input  logic [WID_W-1:0] frm_wid_i,
    output logic             tclk_o,
    output logic             tclk2x_o,
    output logic             frm_o
);
    logic   tick;
    logic   rise;
    logic   rate_act;
    logic   frame_act;
    phase_e phase;
    logic   x2_d, x1_d;
    logic   act_q;

    tdm_nco #(.ACC_W(ACC_W)) u_nco (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (nco_word_i),
        .tick_o (tick)
    );

    tdm_phase_fsm #(.PRESCALE(PRESCALE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .rate_hi_i (rate_act),
        .phase_o   (phase),
        .rise_o    (rise)
    );

    tdm_frame_ctr #(.LO_X1(LO_X1), .HI_X1(HI_X1), .WID_W(WID_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .rate_req_i  (rate_hi_i),
        .wid_req_i   (frm_wid_i),
        .rate_act_o  (rate_act),
        .frame_act_o (frame_act)
    );

    always_comb begin
        unique case (phase)
            PH_BOTH_LO: begin x2_d = 1'b0; x1_d = 1'b0; end
            PH_BOTH_HI: begin x2_d = 1'b1; x1_d = 1'b1; end
            PH_X1_ONLY: begin x2_d = 1'b0; x1_d = 1'b1; end
            PH_X2_ONLY: begin x2_d = 1'b1; x1_d = 1'b0; end
            default:    begin x2_d = 1'b0; x1_d = 1'b0; end
        endcase
    end

    // Output process: all three outputs leave from flops updated together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tclk2x_o <= 1'b0;
            tclk_o   <= 1'b0;
            act_q    <= 1'b0;
            frm_o    <= !frm_pol_i;
        end else begin
            tclk2x_o <= x2_d;
            tclk_o   <= x1_d;
            act_q    <= frame_act;
            frm_o    <= frame_act ~^ frm_pol_i;
        end
    end

    // R3: the common clock moves only on a rising double-rate edge
    assert_x1_on_x2_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tclk_o) |-> $rose(tclk2x_o));
    // R4: a frame opens on a joint rising edge of both clocks
    assert_frame_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_q) |-> ($rose(tclk2x_o) && tclk_o));
endmodule

// File: tb/tdm_timing_gen_bench.sv
module tdm_timing_gen_bench;
    localparam int ACC_W = 32;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [ACC_W-1:0] nco_word;
    logic             rate_hi;
    logic             pol;
    logic [1:0]       wcode;
    logic             tclk, tclk2x, frm;

    int n_cmp  = 0;
    int n_fail = 0;

    logic c_x2, c_x1, c_act, p_x2, p_x1, p_act;

    always #2.5 clk = ~clk;

    tdm_timing_gen #(.ACC_W(ACC_W)) u_tdm_timing_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .nco_word_i (nco_word),
        .rate_hi_i  (rate_hi),
        .frm_pol_i  (pol),
        .frm_wid_i  (wcode),
        .tclk_o     (tclk),
        .tclk2x_o   (tclk2x),
        .frm_o      (frm)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic smp();
        p_x2 = c_x2; p_x1 = c_x1; p_act = c_act;
        @(negedge clk);
        c_x2 = tclk2x; c_x1 = tclk; c_act = (frm == pol);
    endtask

    task automatic wait_start();
        for (int i = 0; i < 20000; i++) begin
            smp();
            if (c_act && !p_act) break;
        end
    endtask

    // Called at a frame-start sample; measures until the next one
    task automatic run_frame(input int hi, input int w, input int new_rate, input int new_wc);
        int cyc = 0, r2 = 0, r1 = 0, act = 1, hi_len = 1, viol = 0;
        bit hi_done = 0;
        int per = hi ? 4 : 16;
        int x2f = hi ? 2048 : 512;
        chk("R4 start aligned", {c_x2, !p_x2, c_x1, !p_x1}, 4'b1111);
        for (int i = 0; i < 20000; i++) begin
            smp();
            cyc++;
            if (cyc == 1000) begin
                if (new_rate >= 0) rate_hi = new_rate[0];
                if (new_wc >= 0) wcode = new_wc[1:0];
            end
            if (c_act && !p_act) break;
            if (c_x2 && !p_x2) r2++;
            if (c_x1 && !p_x1) r1++;
            if (c_x1 != p_x1 && !(c_x2 && !p_x2)) viol++;
            if (c_act) act++;
            if (!hi_done) begin
                if (c_x2) hi_len++;
                else hi_done = 1;
            end
        end
        // the closing start sample carries one rise of each clock
        if (c_x2 && !p_x2) r2++;
        if (c_x1 && !p_x1) r1++;
        chk("R4 frame length cycles", cyc, 8192);
        chk("R4 double-rate cycles per frame", r2, x2f);
        chk("R3 common-clock cycles per frame", r1, x2f / 2);
        chk("R3 common clock moved off a double-rate rise", viol, 0);
        chk("R2 first high half-period", hi_len, per / 2);
        chk("R5 pulse active cycles", act, w * per);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        logic s2, s1, sf;
        int moved;
        rst_n = 1'b0; nco_word = 32'h8000_0000; rate_hi = 1'b0; pol = 1'b1; wcode = 2'd0;
        c_x2 = 0; c_x1 = 0; c_act = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 reset tclk2x", tclk2x, 0);
        chk("R1 reset tclk", tclk, 0);
        chk("R1 reset frm inactive", frm, 0);
        rst_n = 1'b1;
        wait_start();
        // R7: width raised mid-frame shows in the next frame
        run_frame(0, 1, -1, 3);
        // R7: fast rate requested mid-frame, this frame stays slow
        run_frame(0, 4, 1, -1);
        run_frame(1, 4, -1, 1);
        repeat (200) smp();
        // R6: polarity flip reaches frm at the next edge (inactive region)
        pol = 1'b0;
        smp();
        chk("R6 inverted inactive level", frm, 1);
        wait_start();
        chk("R6 active-low level", frm, 0);
        run_frame(1, 2, 0, 2);
        run_frame(0, 3, -1, -1);
        // R8: zero word freezes the outputs
        nco_word = '0;
        repeat (10) smp();
        s2 = tclk2x; s1 = tclk; sf = frm; moved = 0;
        for (int i = 0; i < 300; i++) begin
            smp();
            if (tclk2x != s2 || tclk != s1 || frm != sf) moved++;
        end
        chk("R8 outputs held with zero word", moved, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule